// File: doc/BRIEF.md
# Fast Ethernet Receive Line Decoder

This block turns the sliced three-level line signal of a 100 Mb/s twisted-pair receiver back into MII receive nibbles. One symbol arrives on every cycle of the recovered 125 MHz clock. The block first rebuilds the NRZI waveform from the level changes and recovers the NRZ bit stream from it. It then undoes the side-stream scrambling, finds code-group boundaries from the start-of-stream delimiter, and maps each five-bit code group back to a four-bit nibble.

The descrambler has no state of its own at power-up. While it acquires, it loads its shift register from the received stream, using the fact that an idle line carries only ones. It declares lock once a long enough run of bits descrambles to one. After lock it runs freely and watches that idle runs keep appearing. If none appears within a hold window, it drops lock and starts acquiring again.

Frames are reported as a strobe per nibble together with data-valid and error flags. The MAC side samples `rx_data`, `rx_dv` and `rx_er` whenever `rx_stb` is high.

Top module: `fe_rx_decoder`

## Requirements
- R1: The input symbol is coded 2'b00 = level 0, 2'b01 = +1, 2'b11 = -1 (2'b10 is read as 0). A recovered line bit is 1 exactly when a symbol's level differs from the level of the symbol before it, via an NRZI stage and an NRZI-to-NRZ stage.
- R2: While unlocked, the descrambler shifts the complement of each received bit into its 11-bit state. `locked` rises only after IDLE_RUN (default 30) consecutive bits descramble to 1, and stays low before that.
- R3: The keystream obeys k[n] = k[n-11] XOR k[n-9]. Once locked, the state runs freely on its own prediction and each data bit is the received bit XOR the keystream.
- R4: A frame starts when the last ten descrambled bits, oldest first, are 1100010001. No `rx_stb` occurs outside a frame.
- R5: Inside a frame, each group of five bits is decoded, with the first received bit as the group's MSB. The mapping is 11110→0, 01001→1, 10100→2, 10101→3, 01010→4, 01011→5, 01110→6, 01111→7, 10010→8, 10011→9, 10110→A, 10111→B, 11010→C, 11011→D, 11100→E, 11101→F. Each data group gives exactly one single-cycle `rx_stb` with its nibble on `rx_data`.
- R6: `rx_dv` rises together with the strobe of the first data nibble after the delimiter, is high on every strobe of the frame, and falls without a strobe when the group 01101 ends the frame.
- R7: A group that is neither data, 01101 nor 11111 gives a strobe with `rx_er` and `rx_dv` high, and the frame continues. The group 11111 inside a frame gives a strobe with `rx_er` high and then ends the frame.
- R8: When locked, if HOLD_BITS (default 1024) bits pass without a run of IDLE_RUN descrambled ones, `locked` falls. `rx_dv` is low in the same cycle, and acquisition restarts so that a later idle run relocks.
- R9: During and just after reset, `locked`, `rx_dv`, `rx_er` and `rx_stb` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered 125 MHz symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_i | input | 2 | Sliced line level, signed code |
| rx_data | output | 4 | Decoded receive nibble |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error for the current nibble |
| rx_stb | output | 1 | One-cycle pulse when a new nibble is presented |
| locked | output | 1 | Descrambler lock |

## Verification
The assertions check on every cycle that each recovered bit matches the level change two cycles earlier, and that lock rises only when the idle run completes. They also check that lock falls only when the hold window runs out, that strobes are isolated and come only from inside a frame, and that data-valid clears after lock is lost. Only the bench scenarios can show end-to-end correctness. These scenarios drive a scrambled, MLT3-coded frame stream through the whole chain and compare every nibble. They also show that data-valid does not run ahead of the first nibble, that the end and idle codes close frames, and that random line noise breaks lock and a later idle run restores it.

// File: rtl/fe_rx_pkg.sv
package fe_rx_pkg;

    typedef enum logic [1:0] {
        GRP_DATA,
        GRP_END,
        GRP_IDLE,
        GRP_BAD
    } grp_kind_e;

    typedef struct packed {
        grp_kind_e  kind;
        logic [3:0] nib;
    } grp_dec_t;

    // start-of-stream delimiter, oldest bit at the left
    localparam logic [9:0] SSD_PATTERN = 10'b1100010001;

    function automatic grp_dec_t decode_grp(input logic [4:0] g);
        grp_dec_t r;
        r.kind = GRP_DATA;
        r.nib  = 4'h0;
        case (g)
            5'b11110: r.nib = 4'h0;
            5'b01001: r.nib = 4'h1;
            5'b10100: r.nib = 4'h2;
            5'b10101: r.nib = 4'h3;
            5'b01010: r.nib = 4'h4;
            5'b01011: r.nib = 4'h5;
            5'b01110: r.nib = 4'h6;
            5'b01111: r.nib = 4'h7;
            5'b10010: r.nib = 4'h8;
            5'b10011: r.nib = 4'h9;
            5'b10110: r.nib = 4'hA;
            5'b10111: r.nib = 4'hB;
            5'b11010: r.nib = 4'hC;
            5'b11011: r.nib = 4'hD;
            5'b11100: r.nib = 4'hE;
            5'b11101: r.nib = 4'hF;
            5'b01101: r.kind = GRP_END;
            5'b11111: r.kind = GRP_IDLE;
            default:  r.kind = GRP_BAD;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fe_rx_linecode.sv
module fe_rx_linecode (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sym_i,
    output logic       bit_o
);
    typedef struct packed {
        logic [1:0] lvl;
        logic       nrzi;
        logic       nrzi_prev;
        logic       nrz;
        logic [1:0] warm;
    } lc_st_t;

    lc_st_t st_d, st_q;
    logic [1:0] lvl_in;

    always_comb begin
        st_d   = st_q;
        lvl_in = (sym_i == 2'b10) ? 2'b00 : sym_i;
        // stage 1: rebuild NRZI waveform, toggling on every level change
        st_d.lvl       = lvl_in;
        st_d.nrzi      = st_q.nrzi ^ (lvl_in != st_q.lvl);
        // stage 2: NRZI to NRZ, a transition is a one
        st_d.nrzi_prev = st_q.nrzi;
        st_d.nrz       = st_q.nrzi ^ st_q.nrzi_prev;
        if (st_q.warm != 2'd3) st_d.warm = st_q.warm + 2'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_o = st_q.nrz;

    // R1
    bit_tracks_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.warm == 2'd3) |-> (st_q.nrz == ($past(st_q.lvl, 1) != $past(st_q.lvl, 2))));

endmodule

// File: rtl/fe_rx_descram.sv
module fe_rx_descram #(
    parameter int IDLE_RUN  = 30,
    parameter int HOLD_BITS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_i,
    output logic bit_o,
    output logic lock_o
);
    localparam int RUN_W = $clog2(IDLE_RUN + 1);
    localparam int HOLD_W = $clog2(HOLD_BITS + 1);
    localparam logic [RUN_W-1:0]  RUN_MAX   = RUN_W'(IDLE_RUN);
    localparam logic [RUN_W-1:0]  RUN_LAST  = RUN_W'(IDLE_RUN - 1);
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_BITS - 1);

    typedef struct packed {
        logic [10:0]       sr;
        logic              lock;
        logic [RUN_W-1:0]  run;
        logic [HOLD_W-1:0] hold;
        logic              dout;
    } ds_st_t;

    ds_st_t st_d, st_q;
    logic   kp;
    logic   plain;

    always_comb begin
        st_d  = st_q;
        kp    = st_q.sr[10] ^ st_q.sr[8];
        plain = bit_i ^ kp;
        st_d.dout = plain;
        if (!st_q.lock) begin
            // acquisition: idle bits reveal the keystream directly
            st_d.sr   = {st_q.sr[9:0], ~bit_i};
            st_d.hold = '0;
            if (plain) begin
                if (st_q.run == RUN_LAST) begin
                    st_d.lock = 1'b1;
                    st_d.run  = RUN_MAX;
                end else begin
                    st_d.run = st_q.run + RUN_W'(1);
                end
            end else begin
                st_d.run = '0;
            end
        end else begin
            st_d.sr = {st_q.sr[9:0], kp};
            if (!plain)                 st_d.run = '0;
            else if (st_q.run != RUN_MAX) st_d.run = st_q.run + RUN_W'(1);
            if (st_q.run == RUN_MAX) begin
                st_d.hold = '0;
            end else if (st_q.hold == HOLD_LAST) begin
                st_d.lock = 1'b0;
                st_d.run  = '0;
                st_d.hold = '0;
            end else begin
                st_d.hold = st_q.hold + HOLD_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_o  = st_q.dout;
    assign lock_o = st_q.lock;

    // R2
    lock_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.lock) |-> ($past(st_q.run) == RUN_LAST));

    // R8
    unlock_on_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.lock) |-> ($past(st_q.hold) == HOLD_LAST));

endmodule

// File: rtl/fe_rx_align_dec.sv
module fe_rx_align_dec
    import fe_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_i,
    input  logic       lock_i,
    output logic [3:0] data_o,
    output logic       dv_o,
    output logic       er_o,
    output logic       stb_o
);
    typedef struct packed {
        logic       in_frame;
        logic [9:0] win;
        logic [3:0] grp;
        logic [2:0] ph;
        logic [3:0] data;
        logic       dv;
        logic       er;
        logic       stb;
    } ad_st_t;

    ad_st_t   st_d, st_q;
    grp_dec_t dec;

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        dec      = decode_grp({st_q.grp, bit_i});
        if (!lock_i) begin
            st_d.in_frame = 1'b0;
            st_d.win      = '0;
            st_d.ph       = '0;
            st_d.dv       = 1'b0;
            st_d.er       = 1'b0;
        end else if (!st_q.in_frame) begin
            st_d.win = {st_q.win[8:0], bit_i};
            st_d.dv  = 1'b0;
            st_d.er  = 1'b0;
            if ({st_q.win[8:0], bit_i} == SSD_PATTERN) begin
                st_d.in_frame = 1'b1;
                st_d.ph       = '0;
                st_d.win      = '0;
            end
        end else begin
            st_d.grp = {st_q.grp[2:0], bit_i};
            if (st_q.ph == 3'd4) begin
                st_d.ph = '0;
                case (dec.kind)
                    GRP_DATA: begin
                        st_d.stb  = 1'b1;
                        st_d.dv   = 1'b1;
                        st_d.er   = 1'b0;
                        st_d.data = dec.nib;
                    end
                    GRP_BAD: begin
                        st_d.stb  = 1'b1;
                        st_d.dv   = 1'b1;
                        st_d.er   = 1'b1;
                        st_d.data = 4'h0;
                    end
                    GRP_IDLE: begin
                        st_d.stb      = 1'b1;
                        st_d.dv       = 1'b1;
                        st_d.er       = 1'b1;
                        st_d.data     = 4'h0;
                        st_d.in_frame = 1'b0;
                    end
                    default: begin
                        st_d.dv       = 1'b0;
                        st_d.er       = 1'b0;
                        st_d.in_frame = 1'b0;
                    end
                endcase
            end else begin
                st_d.ph = st_q.ph + 3'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o = st_q.data;
    assign dv_o   = st_q.dv;
    assign er_o   = st_q.er;
    assign stb_o  = st_q.stb;

    // R6
    dv_rise_with_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.dv) |-> st_q.stb);

    // R5
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.stb |=> !st_q.stb);

    // R4
    strobe_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.stb |-> $past(st_q.in_frame));

    // R8
    dv_clear_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_i |=> !st_q.dv);

endmodule

// File: rtl/fe_rx_decoder.sv
module fe_rx_decoder #(
    parameter int IDLE_RUN  = 30,
    parameter int HOLD_BITS = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sym_i,
    output logic [3:0] rx_data,
    output logic       rx_dv,
    output logic       rx_er,
    output logic       rx_stb,
    output logic       locked
);
    logic line_bit;
    logic plain_bit;
    logic dec_dv;

    fe_rx_linecode u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .sym_i (sym_i),
        .bit_o (line_bit)
    );

    fe_rx_descram #(
        .IDLE_RUN  (IDLE_RUN),
        .HOLD_BITS (HOLD_BITS)
    ) u_descram (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_i  (line_bit),
        .bit_o  (plain_bit),
        .lock_o (locked)
    );

    fe_rx_align_dec u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_i  (plain_bit),
        .lock_i (locked),
        .data_o (rx_data),
        .dv_o   (dec_dv),
        .er_o   (rx_er),
        .stb_o  (rx_stb)
    );

    // lock loss masks data-valid in the same cycle
    assign rx_dv = dec_dv & locked;

endmodule

// File: tb/sim_fe_rx_decoder.sv
`timescale 1ns/1ps
module sim_fe_rx_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sym = 2'b00;
    logic [3:0] rx_data;
    logic       rx_dv, rx_er, rx_stb, locked;

    always #2.5 clk = ~clk;

    fe_rx_decoder u0 (
        .clk(clk), .rst_n(rst_n), .sym_i(sym),
        .rx_data(rx_data), .rx_dv(rx_dv), .rx_er(rx_er),
        .rx_stb(rx_stb), .locked(locked)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // transmit model: scrambler, NRZI and MLT3 line coding
    logic [10:0] ksr = 11'h5A3;
    int mph = 0;

    function automatic logic [1:0] lvl_of(input int p);
        case (p)
            1:       return 2'b01;
            3:       return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [4:0] enc(input logic [3:0] n);
        case (n)
            4'h0: return 5'b11110; 4'h1: return 5'b01001;
            4'h2: return 5'b10100; 4'h3: return 5'b10101;
            4'h4: return 5'b01010; 4'h5: return 5'b01011;
            4'h6: return 5'b01110; 4'h7: return 5'b01111;
            4'h8: return 5'b10010; 4'h9: return 5'b10011;
            4'hA: return 5'b10110; 4'hB: return 5'b10111;
            4'hC: return 5'b11010; 4'hD: return 5'b11011;
            4'hE: return 5'b11100; default: return 5'b11101;
        endcase
    endfunction

    task automatic send_bit(input logic d);
        logic kb;
        kb  = ksr[10] ^ ksr[8];
        ksr = {ksr[9:0], kb};
        if (d ^ kb) mph = (mph + 1) % 4;
        sym = lvl_of(mph);
        @(negedge clk);
    endtask

    task automatic send_grp(input logic [4:0] g);
        for (int i = 4; i >= 0; i--) send_bit(g[i]);
    endtask

    task automatic idle(input int n);
        repeat (n) send_bit(1'b1);
    endtask

    // capture of strobed nibbles
    int       cap_n = 0;
    logic [3:0] cap_d [0:63];
    bit       cap_e [0:63];
    bit       cap_dvbad = 0, early = 0, viol = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_stb) begin
                if (cap_n < 64) begin
                    cap_d[cap_n] = rx_data;
                    cap_e[cap_n] = rx_er;
                end
                if (!rx_dv) cap_dvbad = 1;
                cap_n++;
            end else if (rx_dv && cap_n == 0) begin
                early = 1;
            end
            if (!locked && rx_dv) viol = 1;
        end
    end

    task automatic clear_cap();
        cap_n = 0; cap_dvbad = 0; early = 0;
    endtask

    task automatic run_frame(input int n, input int bad_pos);
        logic [3:0] exp [0:63];
        logic [3:0] nib;
        clear_cap();
        send_grp(5'b11000);
        send_grp(5'b10001);
        for (int i = 0; i < n; i++) begin
            nib = 4'($urandom);
            exp[i] = nib;
            if (i == bad_pos) send_grp(5'b00000);
            else              send_grp(enc(nib));
        end
        send_grp(5'b01101);
        send_grp(5'b00111);
        idle(40);
        chk(cap_n == n, "R4 R5 nibble count", cap_n, n);
        for (int i = 0; i < n && i < cap_n; i++) begin
            if (i == bad_pos)
                chk(cap_e[i] == 1'b1, "R7 error flag on bad group", cap_e[i], 1);
            else
                chk(cap_d[i] == exp[i] && !cap_e[i], "R3 R5 nibble value", cap_d[i], exp[i]);
        end
        chk(!cap_dvbad, "R6 dv high on every strobe", cap_dvbad, 0);
        chk(!early, "R6 dv not before first nibble", early, 0);
        chk(rx_dv == 1'b0, "R6 dv low after end code", rx_dv, 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        // R9 reset state
        chk(locked == 0 && rx_dv == 0 && rx_er == 0 && rx_stb == 0,
            "R9 reset outputs", {locked, rx_dv, rx_er, rx_stb}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(locked == 0 && rx_dv == 0 && rx_stb == 0, "R9 after reset", {locked, rx_dv, rx_stb}, 0);

        // R1 R2: lock needs a full idle run
        idle(27);
        chk(locked == 1'b0, "R2 no lock before idle run", locked, 0);
        idle(40);
        chk(locked == 1'b1, "R1 R2 lock after idle run", locked, 1);

        // R4: pure idle produces no strobe
        clear_cap();
        idle(200);
        chk(cap_n == 0, "R4 no strobe without delimiter", cap_n, 0);

        // directed boundaries and random frames
        run_frame(1, -1);
        run_frame(40, -1);
        run_frame(5, 0);
        run_frame(6, 5);
        for (int f = 0; f < 12; f++) begin
            int n;
            n = 1 + int'($urandom % 40);
            run_frame(n, (f % 3 == 0) ? int'($urandom % n) : -1);
        end

        // R7: idle code inside a frame ends it with an error
        clear_cap();
        send_grp(5'b11000); send_grp(5'b10001);
        send_grp(enc(4'h9)); send_grp(enc(4'h3));
        send_grp(5'b11111);
        send_grp(enc(4'h0)); send_grp(enc(4'h0)); send_grp(enc(4'h0));
        send_grp(5'b01101); send_grp(5'b00111);
        idle(40);
        chk(cap_n == 3, "R7 idle code ends frame", cap_n, 3);
        chk(cap_e[2] == 1'b1, "R7 error on idle code", cap_e[2], 1);
        chk(cap_d[1] == 4'h3 && !cap_e[1], "R5 nibble before idle code", cap_d[1], 3);
        chk(rx_dv == 1'b0, "R7 dv low after idle code", rx_dv, 0);

        // R8: noise breaks lock, idle restores it
        viol = 0;
        send_grp(5'b11000); send_grp(5'b10001);
        send_grp(enc(4'h5)); send_grp(enc(4'hA));
        for (int i = 0; i < 1100; i++) begin
            int r;
            r = int'($urandom % 3);
            mph = (r == 0) ? 0 : (r == 1) ? 1 : 3;
            sym = lvl_of(mph);
            @(negedge clk);
        end
        chk(locked == 1'b0, "R8 lock lost on noise", locked, 0);
        chk(rx_dv == 1'b0, "R8 dv low when unlocked", rx_dv, 0);
        chk(!viol, "R8 dv never high while unlocked", viol, 0);
        idle(80);
        chk(locked == 1'b1, "R8 relock after idle", locked, 1);
        run_frame(12, -1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule